// File: doc/BRIEF.md
# Clock Buffer Control Register File

This block is the byte-wide configuration store of an eight-output clock fan-out buffer. An SMBus target front end (not part of this block) turns bus transactions into plain strobes: one cycle of `wr_en` with an address and a data byte writes a register, and `rd_data` always shows the register selected by `addr`. The bank holds the per-output enable bits, the masks that let an output ignore its sideband disable input, the output swing and slew codes, the input receiver options, a block-read byte count and two identification constants.

Beyond storage, the block decides whether each clock output runs. It combines the enable bit, the active-low output-enable pin, the sideband disable input with its mask, and a loss-of-signal input. When automatic output disable is on, a loss holds every output in the low/low state. A sticky loss event flag records that a loss happened. Two write locks protect the configuration: one that only a power-on reset can release, and one that software can release. A power-down entry with configuration saving off returns the configuration to its reset values.

Address map: 0x00 output enables (bit i = output i), 0x01 sideband masks, 0x02 OE pin readback, 0x03 sideband input readback, 0x04 control, 0x05 vendor code, 0x06 device code, 0x07 byte count, 0x08 swing code, 0x09 slew high bits, 0x0A slew low bits, 0x0B permanent lock, 0x0C soft lock and loss event.

Top module: `cbr_ctrl_top`

## Requirements
- R1: After reset the enables read 0xFF, masks 0x00, control 0x03 plus the live loss bit, byte count 0x07, swing 0x06, slew high 0xFF, slew low 0x00, both locks and the loss event 0.
- R2: Address 0x05 reads 0x0A and address 0x06 reads 0x08; writes to them change nothing.
- R3: clk_gate[i] is 1 only when enable bit i is 1, oe_n[i] is 0, and either mask bit i is 1 or sb_dis[i] is 0, and no automatic disable is in force.
- R4: Control bit 0 enables automatic output disable; while it is 1 and los_in is 1 every clk_gate bit is 0; while it is 0 los_in has no effect on clk_gate.
- R5: Control bit 4 reads the inverse of los_in in the same cycle; control bits 1, 2, 3 are the save-config, AC-coupled-input and termination bits driving their outputs.
- R6: Address 0x0C bit 1 is the loss event: it is set in any cycle los_in is 1, stays set after los_in falls, and clears on a write with bit 1 = 1; a set in the same cycle wins over the clear.
- R7: Writing bit 0 = 1 to address 0x0B sets the permanent lock; no register write clears it, only rst_n does.
- R8: Address 0x0C bit 0 is the soft lock: a write of bit 0 = 1 sets it when clear and clears it when set, and the clearing write is taken even under the permanent lock.
- R9: While either lock is set every write leaves every register unchanged, except the soft lock clear of R8; reads are never blocked.
- R10: Reserved bits read 0 and ignore writes; unmapped addresses read 0x00 and ignore writes; byte count is 5 bits, swing 4 bits.
- R11: A rising edge of pwr_down while the save-config bit is 0 returns all configuration registers (not locks or loss event) to their R1 values; with the bit at 1 they are kept.
- R12: Address 0x02 reads oe_n and 0x03 reads sb_dis; amp_code is the swing field and slew_code[2i+1:2i] is {slew high bit i, slew low bit i}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| oe_n | input | 8 | Active-low output-enable pins |
| sb_dis | input | 8 | Sideband disable inputs, 1 = disable |
| los_in | input | 1 | Loss-of-signal indicator, 1 = loss |
| pwr_down | input | 1 | Power-down request |
| clk_gate | output | 8 | Run gate per clock output |
| amp_code | output | 4 | Output swing code, 600 mV + 25 mV per step |
| slew_code | output | 16 | Two-bit slew code per output |
| rx_ac_cpl | output | 1 | Input receiver AC-coupled bias enable |
| rx_term_en | output | 1 | Input termination enable |

## Verification
The assertions assume that wr_en is a clean one-cycle strobe with a stable address and data, that los_in is already synchronous to clk, and that pwr_down entry is seen as a level rise sampled on clk. The stimulus drives every input on the falling edge, holds it through the rising edge, and keeps random writes away from the two lock addresses so that the random phase is not frozen early; the locks, power-down restore and loss event are reached by directed sequences instead.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NOUT = 8;
  localparam int BCW  = 5;
  localparam int AMPW = 4;

  localparam logic [AW-1:0] A_ENABLE = 8'h00;
  localparam logic [AW-1:0] A_SBMASK = 8'h01;
  localparam logic [AW-1:0] A_OERB   = 8'h02;
  localparam logic [AW-1:0] A_SBRB   = 8'h03;
  localparam logic [AW-1:0] A_CTRL   = 8'h04;
  localparam logic [AW-1:0] A_VEND   = 8'h05;
  localparam logic [AW-1:0] A_DEV    = 8'h06;
  localparam logic [AW-1:0] A_BCNT   = 8'h07;
  localparam logic [AW-1:0] A_AMP    = 8'h08;
  localparam logic [AW-1:0] A_SLMSB  = 8'h09;
  localparam logic [AW-1:0] A_SLLSB  = 8'h0A;
  localparam logic [AW-1:0] A_PLOCK  = 8'h0B;
  localparam logic [AW-1:0] A_SLOCK  = 8'h0C;

  localparam logic [NOUT-1:0] RST_ENABLE = '1;
  localparam logic [NOUT-1:0] RST_SBMASK = '0;
  localparam logic [NOUT-1:0] RST_SLMSB  = '1;
  localparam logic [NOUT-1:0] RST_SLLSB  = '0;
  localparam logic [BCW-1:0]  RST_BCNT   = 5'd7;
  localparam logic [AMPW-1:0] RST_AMP    = 4'd6;

  typedef struct packed {
    logic aod_en;
    logic save_cfg;
    logic rx_ac;
    logic rx_term;
  } ctrl_t;

  localparam ctrl_t RST_CTRL = '{aod_en: 1'b1, save_cfg: 1'b1, rx_ac: 1'b0, rx_term: 1'b0};

  // Run decision for one output.
  function automatic logic gate_fn(input logic en, input logic oe_pin_n,
                                   input logic mask, input logic sbd,
                                   input logic auto_off);
    return en & ~oe_pin_n & (mask | ~sbd) & ~auto_off;
  endfunction

  // Swing in millivolts for a code.
  function automatic int amp_mv(input logic [AMPW-1:0] code);
    return 600 + 25 * int'(code);
  endfunction

  function automatic logic [DW-1:0] ctrl_byte(input ctrl_t c, input logic los);
    return {3'b000, ~los, c.rx_term, c.rx_ac, c.save_cfg, c.aod_en};
  endfunction
endpackage

// File: rtl/cbr_lock_ctrl.sv
module cbr_lock_ctrl
  import cbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic          wd_bit0,
  output logic          perm_lock,
  output logic          soft_lock,
  output logic          wr_ok,
  output logic          soft_clear_hit
);
  logic lock_any;
  logic perm_set;
  logic soft_set;

  assign lock_any       = perm_lock | soft_lock;
  assign wr_ok          = wr_en & ~lock_any;
  assign soft_clear_hit = wr_en & (addr == A_SLOCK) & wd_bit0 & soft_lock;
  assign perm_set       = wr_ok & (addr == A_PLOCK) & wd_bit0;
  assign soft_set       = wr_ok & (addr == A_SLOCK) & wd_bit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_lock <= 1'b0;
      soft_lock <= 1'b0;
    end else begin
      if (perm_set) perm_lock <= 1'b1;
      if (soft_clear_hit) soft_lock <= 1'b0;
      else if (soft_set)  soft_lock <= 1'b1;
    end
  end
endmodule

// File: rtl/cbr_los_mon.sv
module cbr_los_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic los_in,
  input  logic evt_clear,
  input  logic pwr_down,
  output logic los_evt,
  output logic pd_enter
);
  logic pd_q;

  assign pd_enter = pwr_down & ~pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_evt <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      pd_q <= pwr_down;
      if (los_in)         los_evt <= 1'b1;
      else if (evt_clear) los_evt <= 1'b0;
    end
  end
endmodule

// File: rtl/cbr_gate.sv
module cbr_gate
  import cbr_pkg::*;
#(
  parameter int N = NOUT
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] oe_n,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] sb_dis,
  input  logic         auto_off,
  output logic [N-1:0] gate
);
  for (genvar i = 0; i < N; i++) begin : g_out
    assign gate[i] = gate_fn(en[i], oe_n[i], mask[i], sb_dis[i], auto_off);
  end
endmodule

// File: rtl/cbr_ctrl_top.sv
module cbr_ctrl_top
  import cbr_pkg::*;
#(
  parameter logic [3:0]    VENDOR_CODE = 4'hA,
  parameter logic [DW-1:0] DEVICE_CODE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NOUT-1:0]   oe_n,
  input  logic [NOUT-1:0]   sb_dis,
  input  logic              los_in,
  input  logic              pwr_down,
  output logic [NOUT-1:0]   clk_gate,
  output logic [AMPW-1:0]   amp_code,
  output logic [2*NOUT-1:0] slew_code,
  output logic              rx_ac_cpl,
  output logic              rx_term_en
);
  logic [NOUT-1:0] en_q, mask_q, slmsb_q, sllsb_q;
  logic [BCW-1:0]  bcnt_q;
  logic [AMPW-1:0] amp_q;
  ctrl_t           ctrl_q;

  // Named internal events for the checker.
  logic perm_lock, soft_lock, wr_ok, soft_clear_hit;
  logic los_evt, pd_enter, cfg_restore, evt_clear, auto_off;

  cbr_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd_bit0(wr_data[0]),
    .perm_lock(perm_lock), .soft_lock(soft_lock), .wr_ok(wr_ok),
    .soft_clear_hit(soft_clear_hit)
  );

  assign evt_clear = wr_ok & (addr == A_SLOCK) & wr_data[1];

  cbr_los_mon u_los (
    .clk(clk), .rst_n(rst_n), .los_in(los_in), .evt_clear(evt_clear),
    .pwr_down(pwr_down), .los_evt(los_evt), .pd_enter(pd_enter)
  );

  assign cfg_restore = pd_enter & ~ctrl_q.save_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= RST_ENABLE; mask_q <= RST_SBMASK; ctrl_q <= RST_CTRL;
      bcnt_q <= RST_BCNT; amp_q <= RST_AMP;
      slmsb_q <= RST_SLMSB; sllsb_q <= RST_SLLSB;
    end else if (cfg_restore) begin
      en_q <= RST_ENABLE; mask_q <= RST_SBMASK; ctrl_q <= RST_CTRL;
      bcnt_q <= RST_BCNT; amp_q <= RST_AMP;
      slmsb_q <= RST_SLMSB; sllsb_q <= RST_SLLSB;
    end else if (wr_ok) begin
      unique case (addr)
        A_ENABLE: en_q    <= wr_data[NOUT-1:0];
        A_SBMASK: mask_q  <= wr_data[NOUT-1:0];
        A_CTRL:   ctrl_q  <= '{aod_en: wr_data[0], save_cfg: wr_data[1],
                               rx_ac: wr_data[2], rx_term: wr_data[3]};
        A_BCNT:   bcnt_q  <= wr_data[BCW-1:0];
        A_AMP:    amp_q   <= wr_data[AMPW-1:0];
        A_SLMSB:  slmsb_q <= wr_data[NOUT-1:0];
        A_SLLSB:  sllsb_q <= wr_data[NOUT-1:0];
        default: ;
      endcase
    end
  end

  assign auto_off = ctrl_q.aod_en & los_in;

  cbr_gate #(.N(NOUT)) u_gate (
    .en(en_q), .oe_n(oe_n), .mask(mask_q), .sb_dis(sb_dis),
    .auto_off(auto_off), .gate(clk_gate)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_slew
    assign slew_code[2*i +: 2] = {slmsb_q[i], sllsb_q[i]};
  end

  assign amp_code   = amp_q;
  assign rx_ac_cpl  = ctrl_q.rx_ac;
  assign rx_term_en = ctrl_q.rx_term;

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_ENABLE: rd_data = en_q;
      A_SBMASK: rd_data = mask_q;
      A_OERB:   rd_data = oe_n;
      A_SBRB:   rd_data = sb_dis;
      A_CTRL:   rd_data = ctrl_byte(ctrl_q, los_in);
      A_VEND:   rd_data = {4'h0, VENDOR_CODE};
      A_DEV:    rd_data = DEVICE_CODE;
      A_BCNT:   rd_data = {{(DW-BCW){1'b0}}, bcnt_q};
      A_AMP:    rd_data = {{(DW-AMPW){1'b0}}, amp_q};
      A_SLMSB:  rd_data = slmsb_q;
      A_SLLSB:  rd_data = sllsb_q;
      A_PLOCK:  rd_data = {7'b0, perm_lock};
      A_SLOCK:  rd_data = {6'b0, los_evt, soft_lock};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cbr_ctrl_chk.sv
module cbr_ctrl_chk
  import cbr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rd_data,
  input logic            los_in,
  input logic [NOUT-1:0] clk_gate,
  input logic [NOUT-1:0] en_q,
  input logic            perm_lock,
  input logic            soft_lock,
  input logic            los_evt,
  input logic            cfg_restore,
  input logic            auto_off
);
  assert_perm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> perm_lock);

  assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (perm_lock || soft_lock) && !cfg_restore) |=> $stable(en_q));

  assert_los_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    los_in |=> los_evt);

  assert_auto_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    auto_off |-> (clk_gate == '0));

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate & ~en_q) == '0);

  assert_vendor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_VEND) |-> (rd_data == 8'h0A));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > A_SLOCK) |-> (rd_data == '0));
endmodule

bind cbr_ctrl_top cbr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
  .los_in(los_in), .clk_gate(clk_gate), .en_q(en_q), .perm_lock(perm_lock),
  .soft_lock(soft_lock), .los_evt(los_evt), .cfg_restore(cfg_restore),
  .auto_off(auto_off)
);

// File: tb/cbr_ctrl_top_tb_top.sv
module cbr_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [7:0]  oe_n = 8'h00;
  logic [7:0]  sb_dis = 8'h00;
  logic        los_in = 1'b0;
  logic        pwr_down = 1'b0;
  logic [7:0]  clk_gate;
  logic [3:0]  amp_code;
  logic [15:0] slew_code;
  logic        rx_ac_cpl, rx_term_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cbr_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .oe_n(oe_n), .sb_dis(sb_dis), .los_in(los_in),
    .pwr_down(pwr_down), .clk_gate(clk_gate), .amp_code(amp_code),
    .slew_code(slew_code), .rx_ac_cpl(rx_ac_cpl), .rx_term_en(rx_term_en)
  );

  // Bench model of the register state.
  logic [7:0] m_en, m_mask, m_msb, m_lsb;
  logic [4:0] m_bc;
  logic [3:0] m_amp;
  logic m_aod, m_save, m_ac, m_term, m_plock, m_slock, m_evt, m_pdq;

  task automatic model_reset();
    m_en = 8'hFF; m_mask = 8'h00; m_msb = 8'hFF; m_lsb = 8'h00;
    m_bc = 5'd7; m_amp = 4'd6; m_aod = 1; m_save = 1; m_ac = 0; m_term = 0;
    m_plock = 0; m_slock = 0; m_evt = 0; m_pdq = 0;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_en;
      8'h01: return m_mask;
      8'h02: return oe_n;
      8'h03: return sb_dis;
      8'h04: return {3'b0, !los_in, m_term, m_ac, m_save, m_aod};
      8'h05: return 8'h0A;
      8'h06: return 8'h08;
      8'h07: return {3'b0, m_bc};
      8'h08: return {4'b0, m_amp};
      8'h09: return m_msb;
      8'h0A: return m_lsb;
      8'h0B: return {7'b0, m_plock};
      8'h0C: return {6'b0, m_evt, m_slock};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_gate();
    logic [7:0] g;
    for (int i = 0; i < 8; i++)
      g[i] = m_en[i] && !oe_n[i] && (m_mask[i] || !sb_dis[i]) && !(m_aod && los_in);
    return g;
  endfunction

  function automatic logic [15:0] exp_slew();
    logic [15:0] s;
    for (int i = 0; i < 8; i++) s[2*i +: 2] = {m_msb[i], m_lsb[i]};
    return s;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_read(input string tag, input logic [7:0] a);
    addr = a;
    #1;
    chk(tag, {8'h0, rd_data}, {8'h0, exp_read(a)});
  endtask

  // One clock: drive at the falling edge, model the rising edge, return at the next falling edge.
  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d);
    logic lock_any, ok, sclr, restore;
    wr_en = w; addr = a; wr_data = d;
    lock_any = m_plock | m_slock;
    ok = w && !lock_any;
    sclr = w && a == 8'h0C && d[0] && m_slock;
    restore = pwr_down && !m_pdq && !m_save;
    @(posedge clk);
    m_pdq = pwr_down;
    if (los_in) m_evt = 1'b1;
    else if (ok && a == 8'h0C && d[1]) m_evt = 1'b0;
    if (ok && a == 8'h0B && d[0]) m_plock = 1'b1;
    if (sclr) m_slock = 1'b0;
    else if (ok && a == 8'h0C && d[0]) m_slock = 1'b1;
    if (restore) begin
      m_en = 8'hFF; m_mask = 8'h00; m_msb = 8'hFF; m_lsb = 8'h00;
      m_bc = 5'd7; m_amp = 4'd6; m_aod = 1; m_save = 1; m_ac = 0; m_term = 0;
    end else if (ok) begin
      case (a)
        8'h00: m_en = d;
        8'h01: m_mask = d;
        8'h04: {m_term, m_ac, m_save, m_aod} = d[3:0];
        8'h07: m_bc = d[4:0];
        8'h08: m_amp = d[3:0];
        8'h09: m_msb = d;
        8'h0A: m_lsb = d;
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; pwr_down = 1'b0; los_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    @(negedge clk);
    do_reset();

    // R1 reset values
    for (int a = 0; a < 13; a++) check_read("R1 reset read", 8'(a));
    chk("R1 reset amp", {12'h0, amp_code}, 16'h6);
    chk("R1 reset slew", slew_code, 16'hAAAA);

    // R2 identification constants ignore writes
    step(1, 8'h05, 8'hFF); check_read("R2 vendor", 8'h05);
    step(1, 8'h06, 8'h00); check_read("R2 device", 8'h06);

    // R10 reserved bits and unmapped addresses
    step(1, 8'h0D, 8'hFF); check_read("R10 unmapped", 8'h0D);
    check_read("R10 unmapped high", 8'h80);
    step(1, 8'h08, 8'hFF); check_read("R10 amp width", 8'h08);
    step(1, 8'h07, 8'hFF); check_read("R10 bcnt width", 8'h07);
    step(1, 8'h04, 8'hF3); check_read("R10 ctrl reserved", 8'h04);

    // Random phase: R3 R4 R5 R12
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, d;
      a = 8'($urandom % 14);
      if (a == 8'h0B || a == 8'h0C) a = 8'h00;
      d = 8'($urandom);
      oe_n = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      sb_dis = 8'($urandom);
      los_in = ($urandom % 6 == 0);
      step(($urandom % 2) == 1, a, d);
      #1;
      chk("R3 gate", {8'h0, clk_gate}, {8'h0, exp_gate()});
      chk("R12 slew", slew_code, exp_slew());
      chk("R12 amp", {12'h0, amp_code}, {12'h0, m_amp});
      chk("R5 rx outputs", {14'h0, rx_ac_cpl, rx_term_en}, {14'h0, m_ac, m_term});
      check_read("R5 R12 random read", 8'($urandom % 16));
    end

    do_reset();
    oe_n = 8'h00; sb_dis = 8'h00;

    // R4 automatic disable
    los_in = 1'b1; step(0, 8'h00, 8'h00); #1;
    chk("R4 aod forces low", {8'h0, clk_gate}, 16'h0000);
    check_read("R5 live los", 8'h04);
    step(1, 8'h04, 8'h02); #1;
    chk("R4 aod off", {8'h0, clk_gate}, 16'h00FF);
    los_in = 1'b0;

    // R6 sticky loss event, set wins over clear
    step(0, 8'h00, 8'h00); check_read("R6 sticky", 8'h0C);
    chk("R6 sticky value", {8'h0, exp_read(8'h0C)}, 16'h0002);
    step(1, 8'h0C, 8'h02); check_read("R6 w1c", 8'h0C);
    los_in = 1'b1; step(1, 8'h0C, 8'h02); check_read("R6 set wins", 8'h0C);
    los_in = 1'b0; step(1, 8'h0C, 8'h02); check_read("R6 clear", 8'h0C);

    // R11 power-down restore
    step(1, 8'h04, 8'h00); step(1, 8'h00, 8'h0F); step(1, 8'h08, 8'h03);
    pwr_down = 1'b1; step(0, 8'h00, 8'h00);
    check_read("R11 restore en", 8'h00); check_read("R11 restore amp", 8'h08);
    check_read("R11 restore ctrl", 8'h04);
    pwr_down = 1'b0; step(0, 8'h00, 8'h00);
    step(1, 8'h08, 8'h09);
    pwr_down = 1'b1; step(0, 8'h00, 8'h00);
    check_read("R11 saved amp", 8'h08);
    pwr_down = 1'b0; step(0, 8'h00, 8'h00);

    // R8 / R9 soft lock
    step(1, 8'h0C, 8'h01); check_read("R8 soft set", 8'h0C);
    step(1, 8'h00, 8'h00); check_read("R9 soft blocks", 8'h00);
    los_in = 1'b1; step(0, 8'h00, 8'h00); los_in = 1'b0;
    step(1, 8'h0C, 8'h03); check_read("R8 soft clear only", 8'h0C);
    step(1, 8'h00, 8'h55); check_read("R8 write after clear", 8'h00);
    step(1, 8'h0C, 8'h02);

    // R7 permanent lock, soft clear still taken under it
    step(1, 8'h0C, 8'h01);
    step(1, 8'h0B, 8'h01); check_read("R7 perm stays clear under soft", 8'h0B);
    step(1, 8'h0C, 8'h01); check_read("R8 clear under lock", 8'h0C);
    step(1, 8'h0B, 8'h01); check_read("R7 perm set", 8'h0B);
    step(1, 8'h00, 8'hAA); check_read("R9 perm blocks", 8'h00);
    step(1, 8'h0B, 8'h00); check_read("R7 no write clear", 8'h0B);
    step(1, 8'h0C, 8'h01); check_read("R9 soft set blocked", 8'h0C);
    do_reset(); check_read("R7 reset clears", 8'h0B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule